// File: doc/BRIEF.md
# Carrier Board Mode and Rail Controller

This block is the board-management logic of a carrier board. On release of the power-on reset, and again each time the user reset button is pressed, it reads a bank of DIP switches and latches one control mode. From that mode it drives a three-bit voltage-select code for an adjustable I/O supply. It also drives the enable for that supply and a power-good flag toward the mezzanine connector.

Three modes exist, chosen in priority order:
- **Direct mode** is available only on newer boards. It takes the voltage code straight from three switches and leaves two preset switches free as user inputs.
- **Preset mode** maps two switches onto three fixed voltages.
- **Register mode** is the fourth preset setting. In it, the voltage code, supply enable and power-good come from a small register write port.

Around this, the block does four more things:
- It produces an active-low module reset from the synchronized button.
- It selects SD or flash boot from a card-detect input.
- It forwards the two UART lines between a USB bridge and the module.
- It steers the JTAG chain either to the module or to the controller's own test port.

Top module: `board_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, `vsel_o` is 3'b101 (1.8 V), and `rail_en_o` and `pg_o` are 1. At the first rising clock edge after `rst_ni` rises, the mode and code are latched from the switches without a button press.
- R2: The latched mode and code change only at that first edge after reset or while the synchronized button is high. Switch changes at any other time leave `vsel_o` unchanged.
- R3: Direct mode is latched when `rev_new_i` is 1 and `dir_sw_i` is nonzero. `vsel_o` then equals `dir_sw_i`, where ON is 1 and `dir_sw_i[2]` is the first switch. The codes are 111 = 3.3 V, 110 = 2.5 V, 101 = 1.8 V, 100 = 1.5 V, 011 = 1.25 V, 010 = 1.2 V and 001 = 0.8 V.
- R4: When `rev_new_i` is 0, or `dir_sw_i` is 3'b000, direct mode is not taken and the preset switches decide the mode.
- R5: `preset_sw_i` decodes as follows, with bit 1 as the first switch:
  - 00 gives `vsel_o` = 101.
  - 01 gives 110.
  - 10 gives 111.
  - 11 selects register mode.
- R6: In direct mode, `user_sw_o` equals `preset_sw_i` and register mode cannot be entered. In the other modes `user_sw_o` is 2'b00.
- R7: Outside register mode, `rail_en_o` and `pg_o` are 1 whatever the registers hold.
- R8: In register mode, the port value is set by a write with `reg_we_i` high at the clock edge. The output follows on the next cycle. Each target is listed with its reset value:
  - Address 0, bit 0 drives `rail_en_o` (reset 1).
  - Address 0, bit 1 drives `pg_o` (reset 1).
  - Address 1, bits [2:0] drive `vsel_o` (reset 101).
  - Writes to any other address change nothing.
- R9: `mod_pwr_en_o` is always 1.
- R10: `mod_rst_no` goes low SYNC_STAGES rising edges after `rst_btn_i` goes high. It stays low while the button is held and returns high SYNC_STAGES edges after release.
- R11: `boot_sd_o` follows `card_det_i`. A value of 1 means a card is present and selects SD boot; 0 selects flash boot.
- R12: With `jtag_sel_i` = 0, the header TCK/TMS/TDI pass to the bridge outputs and the bridge TDO passes to `hdr_tdo_o`. The controller port then idles at TCK = 0, TMS = 1, TDI = 1. With `jtag_sel_i` = 1, the roles swap: header lines go to the controller port, `hdr_tdo_o` takes `ctl_tdo_i`, and the bridge outputs idle at the same values.
- R13: `mod_rxd_o` equals `br_txd_i`, and `br_rxd_o` equals `mod_txd_i`, with no clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| rst_btn_i | input | 1 | User reset button, 1 = pressed |
| rev_new_i | input | 1 | Board supports direct switch mode |
| dir_sw_i | input | 3 | Direct voltage switches, 1 = ON |
| preset_sw_i | input | 2 | Preset voltage switches, 1 = ON |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 3 | Register write data |
| vsel_o | output | 3 | Supply voltage-select code |
| rail_en_o | output | 1 | Adjustable supply enable |
| pg_o | output | 1 | Power-good to mezzanine |
| mod_pwr_en_o | output | 1 | Module power enable |
| mod_rst_no | output | 1 | Active-low module reset |
| user_sw_o | output | 2 | Preset switches as user inputs in direct mode |
| card_det_i | input | 1 | SD card present |
| boot_sd_o | output | 1 | 1 = SD boot, 0 = flash boot |
| jtag_sel_i | input | 1 | 1 = controller on chain, 0 = module on chain |
| hdr_tck_i | input | 1 | Header TCK |
| hdr_tms_i | input | 1 | Header TMS |
| hdr_tdi_i | input | 1 | Header TDI |
| hdr_tdo_o | output | 1 | Header TDO |
| br_tck_o | output | 1 | Bridge-side TCK |
| br_tms_o | output | 1 | Bridge-side TMS |
| br_tdi_o | output | 1 | Bridge-side TDI |
| br_tdo_i | input | 1 | Bridge-side TDO |
| ctl_tck_o | output | 1 | Controller test port TCK |
| ctl_tms_o | output | 1 | Controller test port TMS |
| ctl_tdi_o | output | 1 | Controller test port TDI |
| ctl_tdo_i | input | 1 | Controller test port TDO |
| br_txd_i | input | 1 | UART data from bridge |
| mod_rxd_o | output | 1 | UART data to module |
| mod_txd_i | input | 1 | UART data from module |
| br_rxd_o | output | 1 | UART data to bridge |

## Verification
The bench builds the block with SYNC_STAGES = 2 and ADDR_W = 2. With two synchronizer stages, the button-to-reset latency of R10 is short enough to count edge by edge, while the synchronizer still uses its multi-stage shift path. A 2-bit address leaves address 2 and address 3 unmapped, so writes that must be ignored under R8 can be issued. The switch table covers every direct code, every preset setting, and both revision inputs.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int unsigned VSEL_W = 3;
  localparam int unsigned PSW_W  = 2;

  typedef enum logic [1:0] {
    MODE_PRESET = 2'd0,
    MODE_DIRECT = 2'd1,
    MODE_REG    = 2'd2
  } mode_e;

  localparam logic [VSEL_W-1:0] V_1P8 = 3'b101;
  localparam logic [VSEL_W-1:0] V_2P5 = 3'b110;
  localparam logic [VSEL_W-1:0] V_3P3 = 3'b111;
endpackage

// File: rtl/bmc_mode_latch.sv
module bmc_mode_latch
  import bmc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              btn_i,
  input  logic              rev_new_i,
  input  logic [VSEL_W-1:0] dir_sw_i,
  input  logic [PSW_W-1:0]  preset_sw_i,
  output logic              btn_sync_o,
  output logic              sample_en_o,
  output mode_e             mode_o,
  output logic [VSEL_W-1:0] vsel_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pend_q;
  mode_e                  mode_q, mode_d;
  logic [VSEL_W-1:0]      vsel_q, vsel_d;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= btn_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], btn_i};
      end
    end
  endgenerate

  assign btn_sync_o  = sync_q[SYNC_STAGES-1];
  // first edge after reset samples once, button samples while held
  assign sample_en_o = pend_q | btn_sync_o;

  always_comb begin
    mode_d = MODE_PRESET;
    vsel_d = V_1P8;
    if (rev_new_i && (|dir_sw_i)) begin
      mode_d = MODE_DIRECT;
      vsel_d = dir_sw_i;
    end else begin
      unique case (preset_sw_i)
        2'b00: vsel_d = V_1P8;
        2'b01: vsel_d = V_2P5;
        2'b10: vsel_d = V_3P3;
        default: mode_d = MODE_REG;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
      mode_q <= MODE_PRESET;
      vsel_q <= V_1P8;
    end else begin
      pend_q <= 1'b0;
      if (sample_en_o) begin
        mode_q <= mode_d;
        vsel_q <= vsel_d;
      end
    end
  end

  assign mode_o = mode_q;
  assign vsel_o = vsel_q;
endmodule

// File: rtl/bmc_ctrl_regs.sv
module bmc_ctrl_regs
  import bmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VSEL_W-1:0] wdata_i,
  output logic              en_o,
  output logic              pg_o,
  output logic [VSEL_W-1:0] vsel_o
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_VSEL = ADDR_W'(1);

  logic en_q, pg_q;
  logic [VSEL_W-1:0] vsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      pg_q   <= 1'b1;
      vsel_q <= V_1P8;
    end else if (we_i) begin
      if (addr_i == ADDR_CTRL) begin
        en_q <= wdata_i[0];
        pg_q <= wdata_i[1];
      end
      if (addr_i == ADDR_VSEL) vsel_q <= wdata_i;
    end
  end

  assign en_o   = en_q;
  assign pg_o   = pg_q;
  assign vsel_o = vsel_q;
endmodule

// File: rtl/bmc_route.sv
module bmc_route (
  input  logic jtag_sel_i,
  input  logic hdr_tck_i,
  input  logic hdr_tms_i,
  input  logic hdr_tdi_i,
  output logic hdr_tdo_o,
  output logic br_tck_o,
  output logic br_tms_o,
  output logic br_tdi_o,
  input  logic br_tdo_i,
  output logic ctl_tck_o,
  output logic ctl_tms_o,
  output logic ctl_tdi_o,
  input  logic ctl_tdo_i,
  input  logic br_txd_i,
  output logic mod_rxd_o,
  input  logic mod_txd_i,
  output logic br_rxd_o,
  input  logic card_det_i,
  output logic boot_sd_o
);
  // unselected side parks in a safe TAP state (TCK low, TMS/TDI high)
  always_comb begin
    br_tck_o  = 1'b0;
    br_tms_o  = 1'b1;
    br_tdi_o  = 1'b1;
    ctl_tck_o = 1'b0;
    ctl_tms_o = 1'b1;
    ctl_tdi_o = 1'b1;
    if (jtag_sel_i) begin
      ctl_tck_o = hdr_tck_i;
      ctl_tms_o = hdr_tms_i;
      ctl_tdi_o = hdr_tdi_i;
      hdr_tdo_o = ctl_tdo_i;
    end else begin
      br_tck_o  = hdr_tck_i;
      br_tms_o  = hdr_tms_i;
      br_tdi_o  = hdr_tdi_i;
      hdr_tdo_o = br_tdo_i;
    end
  end

  assign mod_rxd_o = br_txd_i;
  assign br_rxd_o  = mod_txd_i;
  assign boot_sd_o = card_det_i;
endmodule

// File: rtl/board_mode_ctrl.sv
module board_mode_ctrl
  import bmc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_btn_i,
  input  logic              rev_new_i,
  input  logic [2:0]        dir_sw_i,
  input  logic [1:0]        preset_sw_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [2:0]        reg_wdata_i,
  output logic [2:0]        vsel_o,
  output logic              rail_en_o,
  output logic              pg_o,
  output logic              mod_pwr_en_o,
  output logic              mod_rst_no,
  output logic [1:0]        user_sw_o,
  input  logic              card_det_i,
  output logic              boot_sd_o,
  input  logic              jtag_sel_i,
  input  logic              hdr_tck_i,
  input  logic              hdr_tms_i,
  input  logic              hdr_tdi_i,
  output logic              hdr_tdo_o,
  output logic              br_tck_o,
  output logic              br_tms_o,
  output logic              br_tdi_o,
  input  logic              br_tdo_i,
  output logic              ctl_tck_o,
  output logic              ctl_tms_o,
  output logic              ctl_tdi_o,
  input  logic              ctl_tdo_i,
  input  logic              br_txd_i,
  output logic              mod_rxd_o,
  input  logic              mod_txd_i,
  output logic              br_rxd_o
);
  logic              btn_sync;
  logic              sample_en;
  mode_e             mode_q;
  logic [VSEL_W-1:0] lat_vsel;
  logic              reg_en, reg_pg;
  logic [VSEL_W-1:0] reg_vsel;

  bmc_mode_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .btn_i       (rst_btn_i),
    .rev_new_i   (rev_new_i),
    .dir_sw_i    (dir_sw_i),
    .preset_sw_i (preset_sw_i),
    .btn_sync_o  (btn_sync),
    .sample_en_o (sample_en),
    .mode_o      (mode_q),
    .vsel_o      (lat_vsel)
  );

  bmc_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .en_o    (reg_en),
    .pg_o    (reg_pg),
    .vsel_o  (reg_vsel)
  );

  bmc_route u_route (
    .jtag_sel_i (jtag_sel_i),
    .hdr_tck_i  (hdr_tck_i),
    .hdr_tms_i  (hdr_tms_i),
    .hdr_tdi_i  (hdr_tdi_i),
    .hdr_tdo_o  (hdr_tdo_o),
    .br_tck_o   (br_tck_o),
    .br_tms_o   (br_tms_o),
    .br_tdi_o   (br_tdi_o),
    .br_tdo_i   (br_tdo_i),
    .ctl_tck_o  (ctl_tck_o),
    .ctl_tms_o  (ctl_tms_o),
    .ctl_tdi_o  (ctl_tdi_o),
    .ctl_tdo_i  (ctl_tdo_i),
    .br_txd_i   (br_txd_i),
    .mod_rxd_o  (mod_rxd_o),
    .mod_txd_i  (mod_txd_i),
    .br_rxd_o   (br_rxd_o),
    .card_det_i (card_det_i),
    .boot_sd_o  (boot_sd_o)
  );

  always_comb begin
    if (mode_q == MODE_REG) begin
      vsel_o    = reg_vsel;
      rail_en_o = reg_en;
      pg_o      = reg_pg;
    end else begin
      vsel_o    = lat_vsel;
      rail_en_o = 1'b1;
      pg_o      = 1'b1;
    end
  end

  assign user_sw_o    = (mode_q == MODE_DIRECT) ? preset_sw_i : 2'b00;
  assign mod_pwr_en_o = 1'b1;
  assign mod_rst_no   = ~btn_sync;
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker
  import bmc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_en,
  input mode_e             mode_q,
  input logic [VSEL_W-1:0] lat_vsel,
  input logic [VSEL_W-1:0] vsel_o,
  input logic              rail_en_o,
  input logic              pg_o,
  input logic              reg_en,
  input logic              mod_pwr_en_o,
  input logic              jtag_sel_i,
  input logic              hdr_tdo_o,
  input logic              br_tdo_i
);
  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sample_en) |-> ($stable(mode_q) && $stable(lat_vsel)));

  assert_direct_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DIRECT) |-> (vsel_o != '0));

  assert_rails_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_REG) |-> (rail_en_o && pg_o));

  assert_reg_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_REG) |-> (rail_en_o == reg_en));

  assert_mod_power_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_pwr_en_o);

  assert_jtag_module_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jtag_sel_i |-> (hdr_tdo_o == br_tdo_i));
endmodule

bind board_mode_ctrl bmc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_en    (sample_en),
  .mode_q       (mode_q),
  .lat_vsel     (lat_vsel),
  .vsel_o       (vsel_o),
  .rail_en_o    (rail_en_o),
  .pg_o         (pg_o),
  .reg_en       (reg_en),
  .mod_pwr_en_o (mod_pwr_en_o),
  .jtag_sel_i   (jtag_sel_i),
  .hdr_tdo_o    (hdr_tdo_o),
  .br_tdo_i     (br_tdo_i)
);

// File: tb/tb_board_mode_ctrl.sv
`timescale 1ns/1ps
module tb_board_mode_ctrl;
  localparam int SYNC = 2;
  localparam int AW   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_btn = 1'b0, rev_new = 1'b0;
  logic [2:0] dir_sw = '0;
  logic [1:0] preset_sw = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [2:0] reg_wdata = '0;
  logic [2:0] vsel;
  logic rail_en, pg, mod_pwr_en, mod_rst_n, boot_sd, card_det = 1'b0;
  logic [1:0] user_sw;
  logic jtag_sel = 1'b0, hdr_tck = 1'b0, hdr_tms = 1'b0, hdr_tdi = 1'b0, hdr_tdo;
  logic br_tck, br_tms, br_tdi, br_tdo = 1'b0;
  logic ctl_tck, ctl_tms, ctl_tdi, ctl_tdo = 1'b0;
  logic br_txd = 1'b0, mod_rxd, mod_txd = 1'b0, br_rxd;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  board_mode_ctrl #(.SYNC_STAGES(SYNC), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rst_btn_i(rst_btn), .rev_new_i(rev_new),
    .dir_sw_i(dir_sw), .preset_sw_i(preset_sw), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .vsel_o(vsel),
    .rail_en_o(rail_en), .pg_o(pg), .mod_pwr_en_o(mod_pwr_en),
    .mod_rst_no(mod_rst_n), .user_sw_o(user_sw), .card_det_i(card_det),
    .boot_sd_o(boot_sd), .jtag_sel_i(jtag_sel), .hdr_tck_i(hdr_tck),
    .hdr_tms_i(hdr_tms), .hdr_tdi_i(hdr_tdi), .hdr_tdo_o(hdr_tdo),
    .br_tck_o(br_tck), .br_tms_o(br_tms), .br_tdi_o(br_tdi), .br_tdo_i(br_tdo),
    .ctl_tck_o(ctl_tck), .ctl_tms_o(ctl_tms), .ctl_tdi_o(ctl_tdi),
    .ctl_tdo_i(ctl_tdo), .br_txd_i(br_txd), .mod_rxd_o(mod_rxd),
    .mod_txd_i(mod_txd), .br_rxd_o(br_rxd)
  );

  // {rev, dir[2:0], preset[1:0], exp_vsel[2:0], exp_reg_mode, exp_user[1:0]}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 3'b111, 2'b00, 3'b111, 1'b0, 2'b00},
    {1'b1, 3'b110, 2'b11, 3'b110, 1'b0, 2'b11},
    {1'b1, 3'b101, 2'b01, 3'b101, 1'b0, 2'b01},
    {1'b1, 3'b100, 2'b10, 3'b100, 1'b0, 2'b10},
    {1'b1, 3'b011, 2'b00, 3'b011, 1'b0, 2'b00},
    {1'b1, 3'b010, 2'b01, 3'b010, 1'b0, 2'b01},
    {1'b1, 3'b001, 2'b11, 3'b001, 1'b0, 2'b11},
    {1'b1, 3'b000, 2'b00, 3'b101, 1'b0, 2'b00},
    {1'b1, 3'b000, 2'b01, 3'b110, 1'b0, 2'b00},
    {1'b0, 3'b111, 2'b10, 3'b111, 1'b0, 2'b00},
    {1'b0, 3'b101, 2'b11, 3'b101, 1'b1, 2'b00},
    {1'b1, 3'b000, 2'b11, 3'b101, 1'b1, 2'b00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic press();
    @(negedge clk) rst_btn = 1'b1;
    repeat (4) @(negedge clk);
    rst_btn = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [2:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  initial begin
    // R1 reset state
    rev_new = 1'b1; dir_sw = 3'b011;
    repeat (3) @(negedge clk);
    chk("R1 reset vsel", 8'(vsel), 8'h5);
    chk("R1 reset rail_en", 8'(rail_en), 8'h1);
    chk("R1 reset pg", 8'(pg), 8'h1);
    chk("R10 reset mod_rst_no", 8'(mod_rst_n), 8'h1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 sample after reset", 8'(vsel), 8'h3);

    // R2 switch change without button
    dir_sw = 3'b110; preset_sw = 2'b11; rev_new = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 vsel held", 8'(vsel), 8'h3);

    // R3 R4 R5 R6 table
    for (int i = 0; i < NV; i++) begin
      {rev_new, dir_sw, preset_sw} = VEC[i][11:6];
      press();
      chk("R3/R5 vsel", 8'(vsel), 8'(VEC[i][5:3]));
      chk("R6 user_sw", 8'(user_sw), 8'(VEC[i][1:0]));
      chk("R7/R8 rail_en", 8'(rail_en), 8'h1);
      if (VEC[i][2]) chk("R4 reg mode pg", 8'(pg), 8'h1);
    end

    // R8 register mode writes (currently register mode)
    wr(2'd1, 3'b010);
    chk("R8 vsel write", 8'(vsel), 8'h2);
    wr(2'd0, 3'b000);
    chk("R8 en cleared", 8'(rail_en), 8'h0);
    chk("R8 pg cleared", 8'(pg), 8'h0);
    wr(2'd0, 3'b010);
    chk("R8 pg set", 8'(pg), 8'h1);
    chk("R8 en still 0", 8'(rail_en), 8'h0);
    wr(2'd2, 3'b111);
    wr(2'd3, 3'b111);
    chk("R8 unmapped vsel", 8'(vsel), 8'h2);
    chk("R8 unmapped en", 8'(rail_en), 8'h0);

    // R7 leaving register mode overrides register contents
    rev_new = 1'b0; dir_sw = 3'b000; preset_sw = 2'b00;
    press();
    chk("R7 vsel preset", 8'(vsel), 8'h5);
    chk("R7 rail_en forced", 8'(rail_en), 8'h1);
    chk("R7 pg forced", 8'(pg), 8'h1);
    wr(2'd1, 3'b001);
    chk("R7 write no effect", 8'(vsel), 8'h5);

    // R9
    chk("R9 mod_pwr_en", 8'(mod_pwr_en), 8'h1);

    // R10 reset latency
    @(negedge clk) rst_btn = 1'b1;
    @(negedge clk);
    chk("R10 one edge", 8'(mod_rst_n), 8'h1);
    @(negedge clk);
    chk("R10 two edges", 8'(mod_rst_n), 8'h0);
    repeat (5) @(negedge clk);
    chk("R10 held", 8'(mod_rst_n), 8'h0);
    rst_btn = 1'b0;
    @(negedge clk);
    chk("R10 release one edge", 8'(mod_rst_n), 8'h0);
    @(negedge clk);
    chk("R10 release two edges", 8'(mod_rst_n), 8'h1);

    // R11
    card_det = 1'b1; #1;
    chk("R11 sd boot", 8'(boot_sd), 8'h1);
    card_det = 1'b0; #1;
    chk("R11 flash boot", 8'(boot_sd), 8'h0);

    // R12
    jtag_sel = 1'b0; hdr_tck = 1'b1; hdr_tms = 1'b0; hdr_tdi = 1'b0;
    br_tdo = 1'b1; ctl_tdo = 1'b0; #1;
    chk("R12 bridge pass", 8'({br_tck, br_tms, br_tdi, hdr_tdo}), 8'b1001);
    chk("R12 ctl idle", 8'({ctl_tck, ctl_tms, ctl_tdi}), 8'b011);
    jtag_sel = 1'b1; #1;
    chk("R12 ctl pass", 8'({ctl_tck, ctl_tms, ctl_tdi, hdr_tdo}), 8'b1000);
    chk("R12 bridge idle", 8'({br_tck, br_tms, br_tdi}), 8'b011);

    // R13
    br_txd = 1'b1; mod_txd = 1'b0; #1;
    chk("R13 uart", 8'({mod_rxd, br_rxd}), 8'b10);
    br_txd = 1'b0; mod_txd = 1'b1; #1;
    chk("R13 uart swap", 8'({mod_rxd, br_rxd}), 8'b01);

    done = 1'b1;
    summary();
  end
endmodule